// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of interrupt request lines, each with a fixed rank, and offers at most one interrupt at a time to a processor. The line index sets the rank: index 0 is the most urgent. The processor takes the offered interrupt with an acknowledge pulse. The interrupt handler signals its end with an end-of-service pulse.

A mode input chooses between two disciplines. In sequential mode, nothing is offered while a service is running. Requests that arrive in that time are remembered and are then served one by one, most urgent first. In nested mode, a request that outranks the running service is offered at once. The levels in service are kept on a stack, so that when a preempting service ends, the service it interrupted becomes current again. The mode input is sampled only while no service is running.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `irq_vec_o` is 0, nothing is pending, nothing is in service and the mode is sequential.
- R2: A cycle with `req_i[k]` high marks line k pending. The interrupt is offered from the clock edge that samples that request, provided line k is eligible. A further request on a line that is already pending does not add a second event: after one acknowledge of line k, line k is not offered again unless a new request arrives.
- R3: Among the pending lines that are eligible, `irq_vec_o` gives the lowest index. Once `irq_o` is high, it stays high until an acknowledge is taken.
- R4: An acknowledge (`ack_i` high while `irq_o` is high) clears the pending bit of line `irq_vec_o` and pushes that level onto the in-service stack. An acknowledge while `irq_o` is low changes nothing.
- R5: In sequential mode (mode value 0), `irq_o` stays low while any service is running. Requests that arrive in that time stay pending. After the end of service, they are offered one after another, lowest index first.
- R6: In nested mode (mode value 1), a pending line whose index is lower than the level on top of the stack is offered at once while that service runs.
- R7: In nested mode, a pending line whose index is equal to or higher than the top-of-stack level is not offered until that level is popped.
- R8: End-of-service pops the top stack entry, and the level beneath it becomes the current level. When the stack becomes empty, all pending lines become eligible. End-of-service with an empty stack has no effect. The stack holds at most N entries.
- R9: A new value on `nest_mode_i` takes effect only when it is sampled while the stack is empty. While a service is running, the mode is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_LINES | Request pulses, one per line; index 0 is the most urgent |
| nest_mode_i | input | 1 | 0 = sequential, 1 = nested; sampled while the stack is empty |
| ack_i | input | 1 | Acknowledge of the offered interrupt |
| eos_i | input | 1 | End of the current service |
| irq_o | output | 1 | Interrupt offered to the processor |
| irq_vec_o | output | VEC_W | Index of the offered line |

## Verification
On every cycle, the assertions check the following. An offered line is pending and, in nested mode, outranks the top of the stack. Sequential mode offers nothing while a service runs. An offer persists until it is acknowledged. A level that was just acknowledged is not offered again at once. The mode holds during service, and the stack depth stays within bounds. Only the bench's scenarios can show the order in which held requests drain, the resumption of a preempted level after end-of-service, and that extra pulses on a line that is already pending are absorbed. The bench shows these by comparing the offered vector against hand-computed values and against an arithmetic reference across a long pseudo-random sweep.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic {
    SVC_SEQ  = 1'b0,
    SVC_NEST = 1'b1
  } svc_mode_e;

endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int N_LINES = 8,
  localparam int VEC_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic               clr_en,
  input  logic [VEC_W-1:0]   clr_idx,
  output logic [N_LINES-1:0] pend_q,
  output logic [N_LINES-1:0] pend_nxt
);

  logic [N_LINES-1:0] clr_mask;

  for (genvar i = 0; i < N_LINES; i++) begin : g_clr
    localparam logic [VEC_W-1:0] LINE = VEC_W'(i);
    assign clr_mask[i] = clr_en && (clr_idx == LINE);
  end

  // A new request wins over a clear of the same line in the same cycle.
  always_comb begin
    pend_nxt = (pend_q & ~clr_mask) | req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (clr_en || (|req_i)) begin
      pend_q <= pend_nxt;
    end
  end

endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
  parameter int N_LINES = 8,
  localparam int VEC_W = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int DEP_W = $clog2(N_LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [VEC_W-1:0] push_idx,
  output logic [DEP_W-1:0] depth_q,
  output logic [VEC_W-1:0] top_q,
  output logic [DEP_W-1:0] depth_nxt,
  output logic [VEC_W-1:0] top_nxt
);

  logic [VEC_W-1:0] ent_q   [N_LINES];
  logic [VEC_W-1:0] ent_nxt [N_LINES];
  logic [DEP_W-1:0] slot;
  logic             stk_en;

  // Push with pop replaces the top entry in place.
  always_comb begin
    slot      = pop ? (depth_q - DEP_W'(1)) : depth_q;
    depth_nxt = depth_q;
    if (push && !pop) begin
      depth_nxt = depth_q + DEP_W'(1);
    end else if (pop && !push) begin
      depth_nxt = depth_q - DEP_W'(1);
    end
  end

  for (genvar e = 0; e < N_LINES; e++) begin : g_ent
    localparam logic [DEP_W-1:0] SLOT_ID = DEP_W'(e);
    assign ent_nxt[e] = (push && (slot == SLOT_ID)) ? push_idx : ent_q[e];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (push && (slot == SLOT_ID)) begin
        ent_q[e] <= ent_nxt[e];
      end
    end
  end

  always_comb begin
    top_q   = '0;
    top_nxt = '0;
    for (int e = 0; e < N_LINES; e++) begin
      if (depth_q == DEP_W'(e + 1)) begin
        top_q = ent_q[e];
      end
      if (depth_nxt == DEP_W'(e + 1)) begin
        top_nxt = ent_nxt[e];
      end
    end
  end

  assign stk_en = push || pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else if (stk_en) begin
      depth_q <= depth_nxt;
    end
  end

endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int N_LINES = 8,
  localparam int VEC_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] pend,
  input  logic               stk_empty,
  input  logic               nest,
  input  logic [VEC_W-1:0]   top,
  output logic               hit,
  output logic [VEC_W-1:0]   idx
);

  logic [N_LINES-1:0] elig;

  for (genvar i = 0; i < N_LINES; i++) begin : g_elig
    localparam logic [VEC_W-1:0] LINE = VEC_W'(i);
    logic outranks;
    assign outranks = LINE < top;
    assign elig[i]  = pend[i] && (stk_empty || (nest && outranks));
  end

  always_comb begin
    hit = |elig;
    idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (elig[i]) begin
        idx = VEC_W'(i);
      end
    end
  end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int VEC_W = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int DEP_W = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_i,
  input  logic               nest_mode_i,
  input  logic               ack_i,
  input  logic               eos_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   irq_vec_o
);

  logic               irq_q;
  logic [VEC_W-1:0]   vec_q;
  svc_mode_e          mode_q;
  svc_mode_e          mode_nxt;
  logic               ack_take;
  logic               eos_take;
  logic               mode_en;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] pend_nxt;
  logic [DEP_W-1:0]   depth_q;
  logic [DEP_W-1:0]   depth_nxt;
  logic [VEC_W-1:0]   top_q;
  logic [VEC_W-1:0]   top_nxt;
  logic               sel_hit;
  logic [VEC_W-1:0]   sel_idx;

  assign ack_take = ack_i && irq_q;
  assign eos_take = eos_i && (depth_q != '0);
  assign mode_en  = (depth_q == '0);

  always_comb begin
    mode_nxt = mode_q;
    if (mode_en) begin
      mode_nxt = svc_mode_e'(nest_mode_i);
    end
  end

  irqc_pending #(.N_LINES(N_LINES)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .clr_en   (ack_take),
    .clr_idx  (vec_q),
    .pend_q   (pend_q),
    .pend_nxt (pend_nxt)
  );

  irqc_stack #(.N_LINES(N_LINES)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_take),
    .pop       (eos_take),
    .push_idx  (vec_q),
    .depth_q   (depth_q),
    .top_q     (top_q),
    .depth_nxt (depth_nxt),
    .top_nxt   (top_nxt)
  );

  // The offer is chosen from next-cycle state, so the outputs are registered
  // and still drop in the cycle that follows an acknowledge.
  irqc_select #(.N_LINES(N_LINES)) u_sel (
    .pend      (pend_nxt),
    .stk_empty (depth_nxt == '0),
    .nest      (mode_nxt == SVC_NEST),
    .top       (top_nxt),
    .hit       (sel_hit),
    .idx       (sel_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SVC_SEQ;
    end else if (mode_en) begin
      mode_q <= mode_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= sel_hit;
      vec_q <= sel_idx;
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
  parameter int N_LINES = 8,
  localparam int VEC_W = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int DEP_W = $clog2(N_LINES + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   irq_vec_o,
  input logic [N_LINES-1:0] pend_q,
  input logic [DEP_W-1:0]   depth_q,
  input logic [VEC_W-1:0]   top_q,
  input logic               mode_q
);

  // R2
  offer_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend_q[irq_vec_o]);

  // R3
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> irq_o);

  // R4
  ack_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> !(irq_o && (irq_vec_o == $past(irq_vec_o))));

  // R5
  seq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((depth_q != '0) && !mode_q) |-> !irq_o);

  // R6
  nest_outrank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((depth_q != '0) && mode_q && irq_o) |-> (irq_vec_o < top_q));

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEP_W'(N_LINES));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_q != '0) |=> $stable(mode_q));

endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack_i     (ack_i),
  .irq_o     (irq_o),
  .irq_vec_o (irq_vec_o),
  .pend_q    (pend_q),
  .depth_q   (depth_q),
  .top_q     (top_q),
  .mode_q    (mode_q)
);

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int VW = 2;
  localparam int SWEEP = 4000;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          mode_in;
  logic          ack;
  logic          eos;
  logic          irq;
  logic [VW-1:0] vec;

  int total;
  int bad;
  bit finished;

  // reference state
  logic [N-1:0] m_pend;
  int           m_stk [N];
  int           m_dep;
  logic         m_mode;
  logic         m_irq;
  int           m_vec;

  nest_irq_ctrl #(.N_LINES(N)) u_nest_irq_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .nest_mode_i (mode_in),
    .ack_i       (ack),
    .eos_i       (eos),
    .irq_o       (irq),
    .irq_vec_o   (vec)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string tag, input logic e_irq, input int e_vec);
    total++;
    if (irq !== e_irq || (e_irq && int'(vec) != e_vec)) begin
      bad++;
      $display("FAIL %s: irq=%0b vec=%0d expected irq=%0b vec=%0d", tag, irq, vec, e_irq, e_vec);
    end
  endtask

  task automatic model_step(input logic [N-1:0] r, input logic a, input logic e, input logic m);
    bit push;
    bit pop;
    push = a && m_irq;
    pop  = e && (m_dep > 0);
    if (push) m_pend[m_vec] = 1'b0;
    m_pend = m_pend | r;
    if (m_dep == 0) m_mode = m;
    if (push && pop) m_stk[m_dep-1] = m_vec;
    else if (pop) m_dep--;
    else if (push) begin
      m_stk[m_dep] = m_vec;
      m_dep++;
    end
    m_irq = 1'b0;
    m_vec = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_pend[i] && (m_dep == 0 || (m_mode && i < m_stk[m_dep-1]))) begin
        m_irq = 1'b1;
        m_vec = i;
      end
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input logic a, input logic e, input logic m);
    req = r; ack = a; eos = e; mode_in = m;
    @(posedge clk);
    model_step(r, a, e, m);
    @(negedge clk);
    req = '0; ack = 1'b0; eos = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    total = 0; bad = 0; finished = 0;
    req = '0; ack = 0; eos = 0; mode_in = 0; rst_n = 0;
    m_pend = '0; m_dep = 0; m_mode = 0; m_irq = 0; m_vec = 0;
    for (int i = 0; i < N; i++) m_stk[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset", 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 1'b0, 0);

    // sequential mode
    cyc(4'b0100, 0, 0, 0); chk("R2 line2 request offered", 1, 2);
    cyc(4'b0000, 0, 0, 0); chk("R3 offer held", 1, 2);
    cyc(4'b0010, 0, 0, 0); chk("R3 lowest index wins", 1, 1);
    cyc(4'b0010, 0, 0, 0); chk("R2 repeat on pending line", 1, 1);
    cyc(4'b0000, 1, 0, 0); chk("R5 quiet while serving", 0, 0);
    cyc(4'b0001, 0, 0, 0); chk("R5 new request held", 0, 0);
    cyc(4'b0000, 0, 0, 1); chk("R9 mode ignored in service", 0, 0);
    cyc(4'b0000, 0, 1, 1); chk("R5 drain after end", 1, 0);
    // now in nested mode (sampled with empty stack)
    cyc(4'b0000, 1, 0, 1); chk("R7 lower not offered", 0, 0);
    cyc(4'b0000, 0, 1, 1); chk("R5 next held line", 1, 2);
    cyc(4'b0000, 1, 0, 1); chk("R4 ack enters service", 0, 0);
    cyc(4'b0001, 0, 0, 1); chk("R6 preempt by line0", 1, 0);
    cyc(4'b0000, 1, 0, 1); chk("R4 nested ack", 0, 0);
    cyc(4'b0010, 0, 0, 1); chk("R7 lower than top0", 0, 0);
    cyc(4'b1100, 0, 0, 1); chk("R7 equal or lower", 0, 0);
    cyc(4'b0000, 0, 1, 1); chk("R8 resume level2, line1 eligible", 1, 1);
    cyc(4'b0000, 1, 0, 1); chk("R4 ack line1", 0, 0);
    cyc(4'b0000, 0, 1, 1); chk("R8 back at level2, line2 held", 0, 0);
    cyc(4'b0000, 0, 1, 1); chk("R8 empty stack frees line2", 1, 2);
    cyc(4'b0000, 1, 0, 1); chk("R4 ack line2", 0, 0);
    cyc(4'b0000, 0, 1, 1); chk("R8 line3 next", 1, 3);
    cyc(4'b0000, 1, 0, 1); chk("R4 ack line3", 0, 0);
    cyc(4'b0000, 0, 1, 1); chk("R2 no duplicate events", 0, 0);
    cyc(4'b0000, 0, 1, 1); chk("R8 pop on empty ignored", 0, 0);
    cyc(4'b0000, 1, 0, 1); chk("R4 ack with no offer", 0, 0);
    cyc(4'b1000, 0, 0, 1); chk("R4 stack untouched by stray ack", 1, 3);
    cyc(4'b0000, 1, 0, 1);
    cyc(4'b0000, 0, 1, 1);

    // pseudo-random sweep against the reference
    lfsr = 16'hACE1;
    for (int c = 0; c < SWEEP; c++) begin
      logic [N-1:0] r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = (lfsr[2:0] == 3'd0) ? lfsr[6:3] : '0;
      cyc(r, lfsr[9] & lfsr[10], lfsr[11] & lfsr[12], lfsr[14] | lfsr[15]);
      if (m_mode) chk("R6 sweep nested", m_irq, m_vec);
      else        chk("R5 sweep sequential", m_irq, m_vec);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule